// File: doc/BRIEF.md
# Fully Associative Translation Lookup Array

This block is the matching core of a translation buffer whose contents are loaded by software. It holds a fixed number of entries. Each entry maps a pair of neighbouring virtual pages, one even and one odd, onto two physical frame numbers. A lookup presents a virtual address and the current address-space identifier. All entries are compared at once, and within the same cycle the block reports the winning entry, which half of the pair was addressed, that half's frame number, and whether the half is valid.

Each entry has its own page-size mask, so large and small pages can sit side by side. Addresses are 64 bits wide, but only the two region bits at the top and the low 40 bits take part in matching; the bits between them are ignored. Software loads an entry through a single write port that names the slot to fill. The written contents affect lookups from the next rising clock edge. Permission checks beyond the valid bit, and the sequence that decides what to write, belong to the surrounding logic.

Top module: `tlb_match_array`

## Requirements
- R1: Each entry covers an even/odd page pair. Address bits 12:0 never take part in the compare. Bit j of an entry's size mask removes address bit 13+j from the compare as well. A legal mask is a run of k ones starting at bit 0 (k = 0..16), which gives pages of 4 KiB times 2^k.
- R2: Address bits 61:40 are ignored, both in the lookup address and in the stored page number. Bits 63:62 and the unmasked part of bits 39:13 must be equal for a match.
- R3: An entry matches only if its global bit is 1 or its stored identifier equals the lookup identifier.
- R4: On a match, address bit 12+k of the lookup (k = number of ones in the winning entry's mask) selects the half. A 0 selects the even half, giving its valid bit and frame number, and lk_odd=0. A 1 selects the odd half, and lk_odd=1.
- R5: lk_hit=1 when an entry matches and its selected half is valid. lk_inval=1 when an entry matches and its selected half is invalid. The two are never 1 together. When neither is 1 (a miss), lk_idx, lk_pfn and lk_odd are 0.
- R6: When several entries match, the lowest index wins. lk_multi=1 whenever two or more entries match, whatever their valid bits.
- R7: Lookup is combinational. A write fills entry wr_idx at the rising edge where wr_en=1, becomes visible to lookups after that edge, and leaves all other entries unchanged.
- R8: Reset clears every entry to zero: page number 0, mask 0, identifier 0, not global, both halves invalid, frame numbers 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write the entry named by wr_idx |
| wr_idx | input | 4 | Entry slot to write |
| wr_vpn | input | 64 | Virtual page-pair address to store |
| wr_mask | input | 16 | Page-size mask (run of ones from bit 0) |
| wr_global | input | 1 | Entry matches any identifier |
| wr_asid | input | 8 | Address-space identifier to store |
| wr_valid_even | input | 1 | Even half valid |
| wr_valid_odd | input | 1 | Odd half valid |
| wr_pfn_even | input | 24 | Frame number of the even half |
| wr_pfn_odd | input | 24 | Frame number of the odd half |
| lk_va | input | 64 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_hit | output | 1 | Matching entry with valid selected half |
| lk_inval | output | 1 | Matching entry with invalid selected half |
| lk_multi | output | 1 | Two or more entries match |
| lk_idx | output | 4 | Index of the winning entry |
| lk_odd | output | 1 | Odd half selected |
| lk_pfn | output | 24 | Frame number of the selected half |

## Verification
The bench sends addresses that differ only in bits 61:40 at loaded entries. A design that compared the full width would turn those hits into misses. Lookups on large-page entries vary bit 12+k and the bits just below it. A design that picked the half at a fixed bit, or that compared masked bits, would return the wrong frame or miss. Duplicate entries, identifier mismatches, matches on invalid halves and a lookup during the write cycle are also exercised. These show a priority that picks the higher index, a global bit that is ignored, an invalid match reported as a miss, and a write that takes effect early.

// File: rtl/tlb_match_array.sv
module tlb_match_array #(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int MASK_W     = 16,
  parameter int ASID_W     = 8,
  parameter int PFN_W      = 24,
  parameter int SEG_W      = 40,
  parameter int REG_W      = 2,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              wr_global,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_valid_even,
  input  logic              wr_valid_odd,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_inval,
  output logic              lk_multi,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_odd,
  output logic [PFN_W-1:0]  lk_pfn
);
  localparam logic [VA_W-1:0] KEEP =
    {{REG_W{1'b1}}, {(VA_W-REG_W-SEG_W){1'b0}}, {SEG_W{1'b1}}};
  localparam logic [VA_W-1:0] PAIR_LOW =
    {{(VA_W-PAGE_SHIFT-1){1'b0}}, {(PAGE_SHIFT+1){1'b1}}};

  logic [VA_W-1:0]   e_vpn  [ENTRIES];
  logic [MASK_W-1:0] e_mask [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic [PFN_W-1:0]  e_pfn0 [ENTRIES];
  logic [PFN_W-1:0]  e_pfn1 [ENTRIES];
  logic [ENTRIES-1:0] e_glb, e_v0, e_v1;

  logic [ENTRIES-1:0] match, odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i]  <= '0;
        e_mask[i] <= '0;
        e_asid[i] <= '0;
        e_pfn0[i] <= '0;
        e_pfn1[i] <= '0;
      end
      e_glb <= '0;
      e_v0  <= '0;
      e_v1  <= '0;
    end else if (wr_en) begin
      e_vpn[wr_idx]  <= wr_vpn & KEEP;
      e_mask[wr_idx] <= wr_mask;
      e_asid[wr_idx] <= wr_asid;
      e_pfn0[wr_idx] <= wr_pfn_even;
      e_pfn1[wr_idx] <= wr_pfn_odd;
      e_glb[wr_idx]  <= wr_global;
      e_v0[wr_idx]   <= wr_valid_even;
      e_v1[wr_idx]   <= wr_valid_odd;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VA_W-1:0] cm;
    assign cm = ({{(VA_W-MASK_W){1'b0}}, e_mask[g]} << (PAGE_SHIFT+1)) | PAIR_LOW;
    assign match[g] = (((lk_va ^ e_vpn[g]) & KEEP & ~cm) == '0)
                      && (e_glb[g] || (e_asid[g] == lk_asid));
    assign odd[g] = |(lk_va & ((cm >> 1) + VA_W'(1)));
  end

  logic [IDX_W-1:0] sel;
  logic             any, vsel;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i] && !any) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  assign lk_multi = |(match & (match - ENTRIES'(1)));
  assign lk_odd   = any && odd[sel];
  assign vsel     = lk_odd ? e_v1[sel] : e_v0[sel];
  assign lk_hit   = any && vsel;
  assign lk_inval = any && !vsel;
  assign lk_idx   = sel;
  assign lk_pfn   = !any ? '0 : (lk_odd ? e_pfn1[sel] : e_pfn0[sel]);
endmodule

// File: rtl/tlb_match_array_chk.sv
module tlb_match_array_chk #(
  parameter int IDX_W  = 4,
  parameter int PFN_W  = 24,
  parameter int VA_W   = 64,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [VA_W-1:0]   lk_va,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic              lk_inval,
  input logic              lk_multi,
  input logic [IDX_W-1:0]  lk_idx,
  input logic              lk_odd,
  input logic [PFN_W-1:0]  lk_pfn
);
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_inval));

  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit || lk_inval) |-> (lk_idx == '0 && lk_pfn == '0 && !lk_odd));

  a_r6_multi_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> (lk_hit || lk_inval));

  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(lk_va) && $stable(lk_asid)) |->
      ($stable(lk_hit) && $stable(lk_inval) && $stable(lk_idx) &&
       $stable(lk_pfn) && $stable(lk_multi)));
endmodule

bind tlb_match_array tlb_match_array_chk #(
  .IDX_W(IDX_W), .PFN_W(PFN_W), .VA_W(VA_W), .ASID_W(ASID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lk_va(lk_va), .lk_asid(lk_asid),
  .lk_hit(lk_hit), .lk_inval(lk_inval), .lk_multi(lk_multi),
  .lk_idx(lk_idx), .lk_odd(lk_odd), .lk_pfn(lk_pfn)
);

// File: tb/sim_tlb_match_array.sv
module sim_tlb_match_array;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_idx = 0;
  logic [63:0] wr_vpn = 0;
  logic [15:0] wr_mask = 0;
  logic wr_global = 0;
  logic [7:0] wr_asid = 0;
  logic wr_valid_even = 0, wr_valid_odd = 0;
  logic [23:0] wr_pfn_even = 0, wr_pfn_odd = 0;
  logic [63:0] lk_va = 0;
  logic [7:0] lk_asid = 0;
  logic lk_hit, lk_inval, lk_multi, lk_odd;
  logic [3:0] lk_idx;
  logic [23:0] lk_pfn;

  always #10 clk = ~clk;

  tlb_match_array u0 (.*);

  int total = 0, bad = 0;

  logic [63:0] m_vpn [16];
  int          m_k   [16];
  logic [7:0]  m_asid[16];
  logic        m_g[16], m_v0[16], m_v1[16];
  logic [23:0] m_p0[16], m_p1[16];

  logic x_hit, x_inval, x_multi, x_odd;
  logic [3:0] x_idx;
  logic [23:0] x_pfn;

  task automatic model(input logic [63:0] va, input logic [7:0] asid);
    int n = 0;
    x_hit = 0; x_inval = 0; x_multi = 0; x_odd = 0; x_idx = 0; x_pfn = 0;
    for (int i = 0; i < 16; i++) begin
      int sh = 13 + m_k[i];
      bit m = (va[63:62] == m_vpn[i][63:62]) &&
              ((va[39:0] >> sh) == (m_vpn[i][39:0] >> sh)) &&
              (m_g[i] || m_asid[i] == asid);
      if (m) begin
        if (n == 0) begin
          x_idx = 4'(i);
          x_odd = va[12 + m_k[i]];
          x_pfn = x_odd ? m_p1[i] : m_p0[i];
          x_hit = x_odd ? m_v1[i] : m_v0[i];
          x_inval = !x_hit;
        end
        n++;
      end
    end
    x_multi = (n > 1);
  endtask

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic look(input logic [63:0] va, input logic [7:0] asid, input string tag);
    @(negedge clk);
    lk_va = va; lk_asid = asid;
    #2;
    model(va, asid);
    cmp(tag, "hit", 64'(lk_hit), 64'(x_hit));
    cmp(tag, "inval", 64'(lk_inval), 64'(x_inval));
    cmp(tag, "multi", 64'(lk_multi), 64'(x_multi));
    cmp(tag, "idx", 64'(lk_idx), 64'(x_idx));
    cmp(tag, "odd", 64'(lk_odd), 64'(x_odd));
    cmp(tag, "pfn", 64'(lk_pfn), 64'(x_pfn));
  endtask

  task automatic put(input int idx, input logic [63:0] vpn, input int k, input logic g,
                     input logic [7:0] asid, input logic v0, input logic v1,
                     input logic [23:0] p0, input logic [23:0] p1);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_mask = 16'((32'd1 << k) - 1);
    wr_global = g; wr_asid = asid; wr_valid_even = v0; wr_valid_odd = v1;
    wr_pfn_even = p0; wr_pfn_odd = p1;
    @(posedge clk);
    m_vpn[idx] = vpn; m_k[idx] = k; m_g[idx] = g; m_asid[idx] = asid;
    m_v0[idx] = v0; m_v1[idx] = v1; m_p0[idx] = p0; m_p1[idx] = p1;
    @(negedge clk);
    wr_en = 0;
  endtask

  logic [63:0] pool [6];
  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) begin
      m_vpn[i] = 0; m_k[i] = 0; m_asid[i] = 0; m_g[i] = 0;
      m_v0[i] = 0; m_v1[i] = 0; m_p0[i] = 0; m_p1[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R8: reset state, all entries zero and invalid
    look(64'h0000_0000_1000_0000, 8'h00, "R8 reset miss");
    look(64'h0, 8'h00, "R8 reset zero entries");

    // R7: lookup during write cycle sees old contents, then new after edge
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd3; wr_vpn = 64'h0000_0012_3456_0000; wr_mask = 0;
    wr_global = 1; wr_asid = 0; wr_valid_even = 1; wr_valid_odd = 1;
    wr_pfn_even = 24'h00ABC; wr_pfn_odd = 24'h00ABD;
    lk_va = 64'h0000_0012_3456_0000; lk_asid = 0;
    #2;
    cmp("R7 before edge", "hit", 64'(lk_hit), 64'd0);
    @(posedge clk);
    m_vpn[3] = wr_vpn; m_k[3] = 0; m_g[3] = 1; m_asid[3] = 0;
    m_v0[3] = 1; m_v1[3] = 1; m_p0[3] = 24'h00ABC; m_p1[3] = 24'h00ABD;
    @(negedge clk) wr_en = 0;
    #2;
    cmp("R7 after edge", "hit", 64'(lk_hit), 64'd1);
    cmp("R7 after edge", "pfn", 64'(lk_pfn), 64'h00ABC);

    // R2: middle bits ignored, region bits compared
    put(5, 64'hC000_0045_6780_0000, 0, 1, 8'h0, 1, 1, 24'h111, 24'h222);
    look(64'hC123_4545_6780_0000, 8'h9, "R2 middle bits ignored");
    look(64'h8000_0045_6780_0000, 8'h9, "R2 region bit differs");

    // R3: identifier matching
    put(6, 64'h0000_0077_0000_0000, 0, 0, 8'h07, 1, 1, 24'h333, 24'h444);
    look(64'h0000_0077_0000_1000, 8'h07, "R3 asid equal");
    look(64'h0000_0077_0000_1000, 8'h08, "R3 asid differs");

    // R1/R4: k=2, odd bit 14, bits 13 and 12 inside page
    put(7, 64'h0000_0088_0000_0000, 2, 1, 8'h0, 1, 0, 24'h555, 24'h666);
    look(64'h0000_0088_0000_3FFF, 8'h0, "R1 masked bits ignored");
    look(64'h0000_0088_0000_4000, 8'h0, "R4 odd half invalid");
    look(64'h0000_0088_0000_8000, 8'h0, "R1 above mask miss");

    // R6: duplicate entries, lowest index wins
    put(9, 64'h0000_0099_0000_0000, 0, 1, 8'h0, 1, 1, 24'h777, 24'h778);
    put(4, 64'h0000_0099_0000_0000, 1, 1, 8'h0, 0, 1, 24'h888, 24'h889);
    look(64'h0000_0099_0000_1000, 8'h0, "R6 priority low index");
    look(64'h0000_0099_0000_2000, 8'h0, "R6 multi odd");

    // R5: random mix of writes and lookups
    for (int p = 0; p < 6; p++)
      pool[p] = {$urandom() % 4 == 0 ? 2'b11 : 2'b00, 22'h0, 8'($urandom()), 32'($urandom())};
    for (int it = 0; it < 600; it++) begin
      if ($urandom() % 10 < 3) begin
        put(int'($urandom() % 16), pool[$urandom() % 6], int'($urandom() % 9),
            1'($urandom()), 8'($urandom() % 4), 1'($urandom()), 1'($urandom()),
            24'($urandom()), 24'($urandom()));
      end else begin
        logic [63:0] va = pool[$urandom() % 6] ^ 64'($urandom() % (1 << 21));
        if ($urandom() % 3 == 0) va[61:40] = 22'($urandom());
        look(va, 8'($urandom() % 4), "R5 random");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule